// File: doc/BRIEF.md
# Line Interrupt Down-Counter

This block paces a horizontal (line) interrupt. A timing generator sends it one strobe per display line, at the slot where the line number changes. The strobe's position within the line depends on whether wide or narrow mode is active, and that choice stays with the generator. On each strobe the block compares the current line number with the first inactive line. On inactive lines it reloads an 8-bit down-counter from a reload register. On active lines it counts the counter down. When an active-line strobe finds the counter at zero, the block raises a pending flag and reloads the counter, so one interrupt falls due every reload+1 active lines.

The pending flag stays set until an acknowledge pulse clears it. The request output is the pending flag gated by an enable bit. The block also keeps a frame counter. It steps once per frame, when the strobe arrives on the line eight lines after the first inactive line.

Each strobe is decoded into one of four counter actions: `ACT_HOLD` (no strobe), `ACT_LOAD` (inactive line), `ACT_DEC` (active line, counter non-zero) and `ACT_FIRE` (active line, counter zero). The pending flag is a two-state machine:
- `PEND_IDLE` goes to `PEND_SET` on a fire.
- `PEND_SET` goes to `PEND_IDLE` on an acknowledge that arrives without a fire.
- Every other input leaves the state unchanged.

Top module: `line_irq_counter`

## Requirements
- R1: After reset the pending flag is 0, the request is 0, the frame count is 0 and the down-counter holds 0.
- R2: The counter, the pending flag's set path and the frame count change only on a clock edge with `line_strobe` high. With no strobe, any change on `line_num` has no effect.
- R3: On a strobe with `line_num >= inactive_start` (inactive line, bound inclusive), the counter is loaded with `reload_val`.
- R4: On a strobe on an active line (`line_num < inactive_start`) with a non-zero counter, the counter decreases by one and the pending flag is not set.
- R5: On a strobe on an active line with the counter at zero, the pending flag is set and the counter is reloaded from `reload_val` in the same update. With a reload of N, a run of active lines gives one interrupt every N+1 lines.
- R6: `frame_count` increases by 1, wrapping at its width, exactly on a strobe where `line_num == inactive_start + 8`. Strobes on any other line, such as `inactive_start + 7` or `+ 9`, leave it unchanged.
- R7: `irq` equals `pending & irq_en`. The pending flag is still set while `irq_en` is 0, and `irq` stays low until the enable is set.
- R8: A high `irq_ack` on a clock edge clears the pending flag from the next cycle onward, provided no set happens on the same edge.
- R9: If a set (R5) and `irq_ack` happen on the same edge, the pending flag stays 1.
- R10: `reload_val` is 8 bits wide. The values 0, 1 and 255 give spacings of 1, 2 and 256 active lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_strobe | input | 1 | One-cycle pulse at the line-change slot |
| line_num | input | LINE_W | Current line number |
| inactive_start | input | LINE_W | First inactive (blanking) line |
| reload_val | input | RELOAD_W | Interrupt spacing register, N gives N+1 lines |
| irq_en | input | 1 | Line interrupt enable |
| irq_ack | input | 1 | Acknowledge pulse, clears pending |
| pending | output | 1 | Line interrupt pending flag |
| irq | output | 1 | Interrupt request, pending gated by enable |
| frame_count | output | FRAME_W | Frame counter |

## Verification
On every cycle, the assertions check the following:
- The counter holds between strobes.
- The counter loads on inactive lines.
- The counter decreases by exactly one on non-zero active lines.
- A fire always leaves the flag set.
- A lone acknowledge always clears it.
- The frame count moves only on the target line.

The bench scenarios cover the rest: the end-to-end spacing of N+1 lines for several reload values, the bound of the inactive comparison, the set-over-acknowledge priority seen at the ports, and the enable gating of a flag that was recorded while the enable was low.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;
    typedef enum logic {
        LINE_ACTIVE   = 1'b0,
        LINE_INACTIVE = 1'b1
    } line_kind_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_FIRE = 2'd3
    } cnt_act_e;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_SET  = 1'b1
    } pend_state_e;
endpackage

// File: rtl/lirq_downcount.sv
`timescale 1ns/1ps
module lirq_downcount #(
    parameter int RELOAD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  lirq_pkg::line_kind_e     kind,
    input  logic [RELOAD_W-1:0]      reload,
    output logic                     fire
);
    import lirq_pkg::*;

    localparam logic [RELOAD_W-1:0] CNT_ZERO = '0;

    logic [RELOAD_W-1:0] cnt_q;
    cnt_act_e            act;

    // Decode the action for this cycle from strobe, line kind and counter
    always_comb begin
        if (!strobe)
            act = ACT_HOLD;
        else if (kind == LINE_INACTIVE)
            act = ACT_LOAD;
        else if (cnt_q != CNT_ZERO)
            act = ACT_DEC;
        else
            act = ACT_FIRE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else begin
            unique case (act)
                ACT_HOLD: cnt_q <= cnt_q;
                ACT_LOAD: cnt_q <= reload;
                ACT_DEC:  cnt_q <= cnt_q - 1'b1;
                ACT_FIRE: cnt_q <= reload;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb fire = (act == ACT_FIRE);

    // R2: counter untouched between line strobes
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(cnt_q));

    // R3: inactive-line strobe loads the reload register
    p_inactive_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == LINE_INACTIVE) |=> (cnt_q == $past(reload)));

    // R4: active-line strobe with non-zero count steps down by one
    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == LINE_ACTIVE && cnt_q != CNT_ZERO)
            |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: zero reached on an active line reloads in the same update
    p_fire_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == LINE_ACTIVE && cnt_q == CNT_ZERO)
            |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/lirq_pend_fsm.sv
`timescale 1ns/1ps
module lirq_pend_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    output logic pending
);
    import lirq_pkg::*;

    pend_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: if (fire)         state_d = PEND_SET;
            PEND_SET:  if (ack && !fire) state_d = PEND_IDLE;
            default:                     state_d = PEND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == PEND_SET);

    // R5 / R9: a fire always leaves the flag set, acknowledge or not
    p_fire_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == PEND_SET));

    // R8: lone acknowledge clears the flag
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire) |=> (state_q == PEND_IDLE));

    // R8: flag cannot rise without a fire
    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && state_q == PEND_IDLE) |=> (state_q == PEND_IDLE));
endmodule

// File: rtl/lirq_frame.sv
`timescale 1ns/1ps
module lirq_frame #(
    parameter int LINE_W  = 9,
    parameter int FRAME_W = 8,
    parameter int OFFSET  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [LINE_W-1:0]  line,
    input  logic [LINE_W-1:0]  inact_start,
    output logic [FRAME_W-1:0] frame
);
    localparam int          EXT_W   = LINE_W + 1;
    localparam logic [EXT_W-1:0] OFS_EXT = EXT_W'(OFFSET);

    logic [EXT_W-1:0]   target_line;
    logic               tick;
    logic [FRAME_W-1:0] frame_q;

    always_comb begin
        target_line = {1'b0, inact_start} + OFS_EXT;
        tick        = strobe && ({1'b0, line} == target_line);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    frame_q <= '0;
        else if (tick) frame_q <= frame_q + 1'b1;
    end

    always_comb frame = frame_q;

    // R6: frame count moves only on the target-line strobe
    p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && ({1'b0, line} == {1'b0, inact_start} + OFS_EXT))
            |=> $stable(frame_q));

    p_frame_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && ({1'b0, line} == {1'b0, inact_start} + OFS_EXT))
            |=> (frame_q == $past(frame_q) + 1'b1));
endmodule

// File: rtl/line_irq_counter.sv
`timescale 1ns/1ps
module line_irq_counter #(
    parameter int LINE_W   = 9,
    parameter int RELOAD_W = 8,
    parameter int FRAME_W  = 8,
    parameter int FRAME_OFFSET = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_strobe,
    input  logic [LINE_W-1:0]   line_num,
    input  logic [LINE_W-1:0]   inactive_start,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                irq_en,
    input  logic                irq_ack,
    output logic                pending,
    output logic                irq,
    output logic [FRAME_W-1:0]  frame_count
);
    import lirq_pkg::*;

    line_kind_e kind;
    logic       fire;
    logic       pend_int;

    // Classify the current line (inactive bound is inclusive)
    always_comb kind = (line_num >= inactive_start) ? LINE_INACTIVE : LINE_ACTIVE;

    lirq_downcount #(.RELOAD_W(RELOAD_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (line_strobe),
        .kind   (kind),
        .reload (reload_val),
        .fire   (fire)
    );

    lirq_pend_fsm u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .ack     (irq_ack),
        .pending (pend_int)
    );

    lirq_frame #(
        .LINE_W  (LINE_W),
        .FRAME_W (FRAME_W),
        .OFFSET  (FRAME_OFFSET)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (line_strobe),
        .line        (line_num),
        .inact_start (inactive_start),
        .frame       (frame_count)
    );

    always_comb begin
        pending = pend_int;
        irq     = pend_int & irq_en;
    end

    // R5: a set can only follow an active-line strobe
    p_set_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(line_strobe && line_num < inactive_start));
endmodule

// File: tb/sim_line_irq_counter.sv
`timescale 1ns/1ps
module sim_line_irq_counter;
    localparam int LINE_W = 9;
    localparam int RW     = 8;
    localparam int FW     = 8;
    localparam logic [LINE_W-1:0] INACT  = 9'd224;
    localparam logic [LINE_W-1:0] ACTL   = 9'd10;
    localparam logic [RW-1:0]     RELOADS [4] = '{8'd0, 8'd1, 8'd3, 8'd255};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_strobe = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic [LINE_W-1:0] inactive_start = INACT;
    logic [RW-1:0]     reload_val = '0;
    logic              irq_en = 1'b0;
    logic              irq_ack = 1'b0;
    logic              pending;
    logic              irq;
    logic [FW-1:0]     frame_count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    line_irq_counter u0 (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_num(line_num),
        .inactive_start(inactive_start), .reload_val(reload_val), .irq_en(irq_en),
        .irq_ack(irq_ack), .pending(pending), .irq(irq), .frame_count(frame_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobe on line l; returns at the negedge after the update edge
    task automatic strobe(input logic [LINE_W-1:0] l, input logic with_ack);
        @(negedge clk);
        line_num = l; line_strobe = 1'b1; irq_ack = with_ack;
        @(negedge clk);
        line_strobe = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pending", int'(pending), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 frame", int'(frame_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: counter 0 at reset -> first active strobe fires at once
        strobe(ACTL, 1'b0);
        chk("R1 zero counter fires", int'(pending), 1);
        ack_pulse();
        chk("R8 ack clears", int'(pending), 0);

        // Table walk: spacing N+1 lines (R5, R10, R4)
        irq_en = 1'b1;
        foreach (RELOADS[i]) begin
            int idx;
            reload_val = RELOADS[i];
            strobe(INACT, 1'b0);
            for (int pass = 0; pass < 2; pass++) begin
                idx = -1;
                for (int k = 0; k < 600; k++) begin
                    strobe(ACTL, 1'b0);
                    if (pending) begin idx = k; break; end
                end
                chk("R5 R10 spacing", idx, int'(RELOADS[i]));
                ack_pulse();
            end
        end

        // R3: inactive line (inclusive bound) reloads mid-count
        reload_val = 8'd4;
        strobe(INACT, 1'b0);
        strobe(ACTL, 1'b0);
        strobe(ACTL, 1'b0);
        strobe(INACT, 1'b0);
        begin
            int idx = -1;
            for (int k = 0; k < 20; k++) begin
                strobe(ACTL, 1'b0);
                if (pending) begin idx = k; break; end
            end
            chk("R3 reload on inactive", idx, 4);
        end
        ack_pulse();

        // R2: no strobe -> nothing moves
        reload_val = 8'd2;
        strobe(INACT, 1'b0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            line_num = (k % 2 == 0) ? ACTL : 9'(INACT + 8);
        end
        chk("R2 frame stable", int'(frame_count), 0);
        chk("R2 pending stable", int'(pending), 0);
        strobe(ACTL, 1'b0);
        strobe(ACTL, 1'b0);
        chk("R4 no pending while counting", int'(pending), 0);
        strobe(ACTL, 1'b0);
        chk("R2 counter held", int'(pending), 1);
        ack_pulse();

        // R9: set and ack together, set wins
        reload_val = 8'd0;
        strobe(INACT, 1'b0);
        strobe(ACTL, 1'b0);
        chk("R5 set", int'(pending), 1);
        strobe(ACTL, 1'b1);
        chk("R9 set wins", int'(pending), 1);
        ack_pulse();
        chk("R8 ack alone", int'(pending), 0);
        ack_pulse();
        chk("R8 ack idle", int'(pending), 0);

        // R7: enable gating
        irq_en = 1'b0;
        strobe(ACTL, 1'b0);
        chk("R7 pending recorded", int'(pending), 1);
        chk("R7 irq gated", int'(irq), 0);
        @(negedge clk); irq_en = 1'b1;
        @(negedge clk);
        chk("R7 irq on enable", int'(irq), 1);
        ack_pulse();
        chk("R7 irq after ack", int'(irq), 0);

        // R6: frame counter
        strobe(9'(INACT + 7), 1'b0);
        chk("R6 line +7", int'(frame_count), 0);
        strobe(9'(INACT + 8), 1'b0);
        chk("R6 line +8", int'(frame_count), 1);
        strobe(9'(INACT + 9), 1'b0);
        chk("R6 line +9", int'(frame_count), 1);
        strobe(ACTL, 1'b0);
        chk("R6 active line", int'(frame_count), 1);
        strobe(9'(INACT + 8), 1'b0);
        chk("R6 second frame", int'(frame_count), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule